// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This engine runs on the host side of a parallel flash and waits for a program or erase operation to finish. The flash reports progress through status bits in any word read back while the internal operation runs. The host pulses `start` once the last write of the command sequence has been issued. It supplies the target address, the word being programmed, whether the operation is an erase, a poll-count budget and one of two detection methods. The engine then reads the target location repeatedly through a single-outstanding read port until it sees completion or runs out of budget.

Two detection methods are offered. Data-complement polling looks at bit 7. During a program that bit reads as the inverse of the value being written, and during an erase it reads as 0. Toggle detection looks at bit 6, which flips on every read while the device is busy and settles once the device is idle. A read can coincide with the instant the device finishes, and the returned word may then be inconsistent. For that reason, any apparent completion must be backed by two further reads that also show completion before `done` is raised. If either of those reads disagrees, polling resumes.

Top module: `wr_done_poller`

## Requirements
- R1: `start` is accepted only while `busy` is low. A `start` pulse seen while busy has no effect on the running operation: the address on `rd_addr`, the detection method, the expected word and the poll budget all stay as they were latched.
- R2: Every read request is a one-cycle `rd_req` pulse. Each one targets the address latched at `start`, and `rd_addr` holds that address for the whole operation. The first request follows the accepting edge. Each later request is raised in the cycle after the response that precedes it.
- R3: In data-complement mode (`start_mode` = 0) for a program (`start_erase` = 0), a response counts as showing completion when its bit 7 equals bit 7 of the expected word.
- R4: In data-complement mode for an erase (`start_erase` = 1), a response counts as showing completion when its bit 7 is 1.
- R5: In toggle mode (`start_mode` = 1), a response counts as showing completion when its bit 6 equals bit 6 of the previous response of the same operation. The first response of an operation never counts.
- R6: An apparent completion is followed by two more reads of the same location. `done` is raised only if both show completion. A read that does not show completion returns the engine to polling, and a fresh apparent completion followed by two more confirming reads is then needed.
- R7: `done` is a one-cycle pulse. It is raised in the cycle after the edge that captured the final confirming response, and `busy` is low in that same cycle.
- R8: Responses are counted from `start`. When the count reaches `poll_limit` without completion, `timeout` pulses for one cycle and `busy` drops. If the response that reaches the limit also completes the confirmation, `done` wins and `timeout` stays low.
- R9: A `rd_valid` pulse while no read is outstanding (engine idle) is ignored: no `done`, `timeout`, `rd_req` or `busy` results.
- R10: After reset, `busy`, `rd_req`, `done` and `timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin waiting for a write (taken only when idle) |
| start_mode | input | 1 | 0 = bit-7 data-complement polling, 1 = bit-6 toggle detection |
| start_erase | input | 1 | 1 = the pending operation is an erase |
| start_addr | input | AW | Location being written |
| start_data | input | DW | Word being programmed |
| poll_limit | input | CW | Maximum number of responses before timeout |
| busy | output | 1 | An operation is being polled |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DW | Read response word |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle budget-exhausted pulse |

## Verification
The bench builds the engine with its defaults: 16-bit address and data, a 16-bit poll budget, two confirming reads, and status bits 7 and 6. A 16-bit word holds both status bits along with ordinary data bits, so a simulated flash in the bench can produce busy words, true words and completion-looking glitch words. Small budgets of 4 to 6 responses put both the exact-limit cases and the case where `done` beats `timeout` within a few cycles. The two confirming reads let a single glitch, or a pair of glitches, land on either confirmation step and force the engine back into polling.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } poll_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } poll_state_e;

endpackage

// File: rtl/wdp_status_eval.sv
// Decides whether one returned word shows the write as finished.
module wdp_status_eval
  import wdp_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DPOLL_BIT  = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  poll_mode_e      mode,
  input  logic            erase,
  input  logic [DW-1:0]   exp_word,
  input  logic [DW-1:0]   rd_word,
  input  logic            prev_tb,
  input  logic            prev_vld,
  output logic            looks_done
);

  logic dp_ok;
  logic tg_ok;

  generate
    if (DPOLL_BIT >= DW || TOGGLE_BIT >= DW) begin : g_bad_bits
      initial $error("status bit positions exceed data width");
    end
  endgenerate

  always_comb begin
    dp_ok = erase ? rd_word[DPOLL_BIT] : (rd_word[DPOLL_BIT] == exp_word[DPOLL_BIT]);
    tg_ok = prev_vld && (rd_word[TOGGLE_BIT] == prev_tb);
    looks_done = (mode == MODE_TOGGLE) ? tg_ok : dp_ok;
  end

endmodule

// File: rtl/wdp_confirm_track.sv
// Tracks apparent completion and the confirming reads behind it.
module wdp_confirm_track #(
  parameter int CONFIRM_READS = 2,
  localparam int PW = $clog2(CONFIRM_READS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sample,
  input  logic ok,
  output logic confirmed
);

  logic [PW-1:0] phase;

  assign confirmed = sample && ok && (phase == PW'(CONFIRM_READS));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
    end else if (sample) begin
      if (!ok) begin
        phase <= '0;
      end else if (phase != PW'(CONFIRM_READS)) begin
        phase <= phase + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdp_poll_budget.sv
// Counts responses and flags the one that exhausts the budget.
module wdp_poll_budget #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          exhausted
);

  logic [CW:0] cnt;
  logic [CW:0] cnt_nxt;

  assign cnt_nxt   = cnt + 1'b1;
  assign exhausted = inc && (cnt_nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && !exhausted) begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/wr_done_poller.sv
module wr_done_poller
  import wdp_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 16,
  parameter int CW            = 16,
  parameter int CONFIRM_READS = 2,
  parameter int DPOLL_BIT     = 7,
  parameter int TOGGLE_BIT    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_mode,
  input  logic          start_erase,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  input  logic [CW-1:0] poll_limit,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic          timeout
);

  poll_state_e   state;
  poll_mode_e    job_mode;
  logic          job_erase;
  logic [DW-1:0] job_data;
  logic [CW-1:0] job_limit;
  logic          prev_tb;
  logic          prev_vld;
  logic          rd_req_q;
  logic [AW-1:0] rd_addr_q;
  logic          done_q;
  logic          timeout_q;

  logic accept;
  logic resp;
  logic looks_done;
  logic confirmed;
  logic exhausted;

  assign accept = (state == ST_IDLE) && start;
  assign resp   = (state == ST_WAIT) && rd_valid;

  wdp_status_eval #(
    .DW        (DW),
    .DPOLL_BIT (DPOLL_BIT),
    .TOGGLE_BIT(TOGGLE_BIT)
  ) u_eval (
    .mode      (job_mode),
    .erase     (job_erase),
    .exp_word  (job_data),
    .rd_word   (rd_data),
    .prev_tb   (prev_tb),
    .prev_vld  (prev_vld),
    .looks_done(looks_done)
  );

  wdp_confirm_track #(
    .CONFIRM_READS(CONFIRM_READS)
  ) u_confirm (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .sample   (resp),
    .ok       (looks_done),
    .confirmed(confirmed)
  );

  wdp_poll_budget #(
    .CW(CW)
  ) u_budget (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .inc      (resp),
    .limit    (job_limit),
    .exhausted(exhausted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      job_mode  <= MODE_DATA;
      job_erase <= 1'b0;
      job_data  <= '0;
      job_limit <= '0;
      prev_tb   <= 1'b0;
      prev_vld  <= 1'b0;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      rd_req_q  <= 1'b0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            job_mode  <= poll_mode_e'(start_mode);
            job_erase <= start_erase;
            job_data  <= start_data;
            job_limit <= poll_limit;
            rd_addr_q <= start_addr;
            prev_vld  <= 1'b0;
            rd_req_q  <= 1'b1;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rd_valid) begin
            prev_tb  <= rd_data[TOGGLE_BIT];
            prev_vld <= 1'b1;
            if (confirmed) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else if (exhausted) begin
              timeout_q <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              rd_req_q <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state == ST_WAIT);
  assign rd_req  = rd_req_q;
  assign rd_addr = rd_addr_q;
  assign done    = done_q;
  assign timeout = timeout_q;

endmodule

// File: rtl/wdp_checker.sv
module wdp_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          done,
  input logic          timeout
);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  exclusive_end_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));

  // R8
  timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !busy);

  // R2
  req_in_op_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rd_addr));

  // R1
  start_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && rd_req));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (!busy && !rd_req && !done && !timeout));

endmodule

bind wr_done_poller wdp_checker #(.AW(AW)) u_wdp_checker (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .rd_req  (rd_req),
  .rd_addr (rd_addr),
  .rd_valid(rd_valid),
  .done    (done),
  .timeout (timeout)
);

// File: tb/wr_done_poller_test.sv
`timescale 1ns/1ps
module wr_done_poller_test;

  typedef struct packed {
    logic        mode;
    logic        erase;
    logic [15:0] data;
    logic [7:0]  busy_n;
    logic [7:0]  mask;
    logic [15:0] limit;
    logic        exp_done;
    logic [7:0]  exp_reads;
  } vec_t;

  localparam int NV = 13;

  // busy_n: reads that return a busy word; mask bit i: read i+1 returns the true word early
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 16'h00A5, 8'd3,  8'h00, 16'd20, 1'b1, 8'd6},
    '{1'b0, 1'b1, 16'h0000, 8'd2,  8'h00, 16'd20, 1'b1, 8'd5},
    '{1'b1, 1'b0, 16'h00A5, 8'd3,  8'h00, 16'd20, 1'b1, 8'd7},
    '{1'b1, 1'b0, 16'h00A5, 8'd2,  8'h00, 16'd20, 1'b1, 8'd5},
    '{1'b1, 1'b0, 16'h00A5, 8'd0,  8'h00, 16'd20, 1'b1, 8'd4},
    '{1'b1, 1'b1, 16'h0000, 8'd2,  8'h00, 16'd20, 1'b1, 8'd6},
    '{1'b0, 1'b0, 16'h00A5, 8'd5,  8'h02, 16'd20, 1'b1, 8'd8},
    '{1'b0, 1'b0, 16'h00A5, 8'd5,  8'h06, 16'd20, 1'b1, 8'd8},
    '{1'b0, 1'b0, 16'h00A5, 8'd10, 8'h00, 16'd4,  1'b0, 8'd4},
    '{1'b0, 1'b0, 16'h00A5, 8'd3,  8'h00, 16'd6,  1'b1, 8'd6},
    '{1'b0, 1'b0, 16'h00A5, 8'd3,  8'h00, 16'd5,  1'b0, 8'd5},
    '{1'b0, 1'b0, 16'h0035, 8'd1,  8'h00, 16'd20, 1'b1, 8'd4},
    '{1'b0, 1'b0, 16'h00A5, 8'd0,  8'h00, 16'd20, 1'b1, 8'd3}
  };

  localparam string TAG [NV] = '{
    "R3", "R4", "R5", "R5", "R5", "R5", "R6", "R6", "R8", "R8", "R8", "R3", "R6"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        start_mode = 1'b0;
  logic        start_erase = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] start_data = '0;
  logic [15:0] poll_limit = '0;
  logic        busy;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic        done;
  logic        timeout;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  wr_done_poller uut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_mode (start_mode),
    .start_erase(start_erase),
    .start_addr (start_addr),
    .start_data (start_data),
    .poll_limit (poll_limit),
    .busy       (busy),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .done       (done),
    .timeout    (timeout)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] flash_word(input vec_t v, input int k);
    logic [15:0] truew;
    logic [15:0] w;
    truew = v.erase ? 16'hFFFF : v.data;
    if (k > int'(v.busy_n)) return truew;
    if (k >= 1 && k <= 8 && v.mask[k-1]) return truew;
    w = truew;
    w[7] = v.erase ? 1'b0 : ~v.data[7];
    w[6] = k[0];
    return w;
  endfunction

  task automatic run_op(input vec_t v, input logic [15:0] addr,
                        input bit inject, input string req);
    int  reads = 0;
    int  guard = 0;
    bit  fin = 0;
    bit  got_done = 0;
    bit  got_to = 0;
    bit  addr_ok = 1;
    @(negedge clk);
    start       = 1'b1;
    start_mode  = v.mode;
    start_erase = v.erase;
    start_addr  = addr;
    start_data  = v.data;
    poll_limit  = v.limit;
    @(negedge clk);
    while (!fin && guard < 500) begin
      guard++;
      start    = 1'b0;
      rd_valid = 1'b0;
      if (done || timeout) begin
        fin      = 1;
        got_done = done;
        got_to   = timeout;
        chk(req, "busy low at finish (R7)", 32'(busy), 32'd0);
      end else if (rd_req) begin
        reads++;
        if (rd_addr !== addr) addr_ok = 0;
        rd_data  = flash_word(v, reads);
        rd_valid = 1'b1;
        if (inject && reads == 2) begin
          start      = 1'b1;
          start_addr = ~addr;
          start_mode = ~v.mode;
          start_data = ~v.data;
          poll_limit = 16'd1;
        end
      end
      if (!fin) @(negedge clk);
    end
    chk(req, "outcome done", 32'(got_done), 32'(v.exp_done));
    chk(req, "outcome timeout", 32'(got_to), 32'(!v.exp_done));
    chk(req, "read count", 32'(reads), 32'(v.exp_reads));
    chk("R2", "read address held", 32'(addr_ok), 32'd1);
    @(negedge clk);
    chk("R7", "done one cycle", 32'(done | timeout), 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!ended) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "busy", 32'(busy), 32'd0);
    chk("R10", "rd_req", 32'(rd_req), 32'd0);
    chk("R10", "done", 32'(done), 32'd0);
    chk("R10", "timeout", 32'(timeout), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i], 16'h0100 + 16'(i), 1'b0, TAG[i]);
    end

    // R1: start while busy is ignored (address, mode, data, budget unchanged)
    run_op(VEC[0], 16'h4321, 1'b1, "R1");

    // R9: stray responses while idle
    for (int j = 0; j < 3; j++) begin
      rd_valid = 1'b1;
      rd_data  = 16'h00FF;
      @(negedge clk);
      rd_valid = 1'b0;
      chk("R9", "rd_req while idle", 32'(rd_req), 32'd0);
      chk("R9", "done/timeout while idle", 32'(done | timeout), 32'd0);
      chk("R9", "busy while idle", 32'(busy), 32'd0);
    end

    // R2: first request follows the accepting edge
    @(negedge clk);
    start       = 1'b1;
    start_mode  = 1'b0;
    start_erase = 1'b0;
    start_addr  = 16'hBEEF;
    start_data  = 16'h00A5;
    poll_limit  = 16'd1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "first rd_req", 32'(rd_req), 32'd1);
    chk("R2", "rd_addr", 32'(rd_addr), 32'hBEEF);
    @(negedge clk);
    chk("R2", "rd_req single cycle", 32'(rd_req), 32'd0);
    rd_data  = 16'h0025;
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R8", "limit of one gives timeout", 32'(timeout), 32'd1);

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule